// File: doc/BRIEF.md
# Table-Driven Stream Dispatcher for Shared Processing Units

This block takes the complete pixel sets that several group FIFOs collect and sends them through a smaller pool of shared, fixed-latency processing units. It does not arbitrate between requests. A schedule table, prepared beforehand, assigns each task to a unit and gives it a launch cycle and a length in pixels. For every unit, a sequencer walks the table entries that belong to that unit, in table order. It waits until the entry's launch cycle has come and the source FIFO reports its set as ready. It then reads the FIFO for the task's length, one word per cycle, and does not stop partway through.

A registered input mux feeds the selected FIFO word into the unit. The unit is outside this block and has a fixed 15-cycle pipeline. The lane tag of each word, which is the source FIFO index, travels beside the data through a delay line of matching length. A registered output demux uses that tag to place each result on the output lane of its own task. The path from a FIFO read to the lane output is therefore 17 cycles. The dispatcher also raises a sticky flag when the table gives one unit two tasks whose planned windows overlap.

Top module: `sched_dispatch`

## Requirements
- R1: During reset and after it, `fifo_rd`, `unit_in_valid` and `lane_valid` are all zero and `sched_err` is low.
- R2: The schedule clock is 0 in the first cycle after a `sched_start` pulse and counts up from there. A task's FIFO is never read before the task's launch value. When the FIFO is ready and the unit is free, the first read happens in the launch cycle itself.
- R3: A dispatched task reads its FIFO in exactly `len` consecutive cycles, where `len` is at least 1.
- R4: A read starts only while the FIFO shows `fifo_ready` high and `fifo_empty` low. If the FIFO is not ready at launch, the unit stays idle and starts in the first cycle in which the FIFO is ready.
- R5: Each unit serves its entries in table order and never interrupts a task. The next task on a unit starts no earlier than the cycle after the previous task's last read.
- R6: Every read produces one valid beat on output lane `f`, where `f` is the task's FIFO index. The beat appears exactly 17 cycles after the read cycle, and beats keep their read order.
- R7: The unit input data is the head word of the selected FIFO. The lane data is the unit output, passed on unchanged.
- R8: `sched_err` goes high when a unit moves to a table entry whose launch is less than the previous entry's launch plus its `len`. It stays high until the next `sched_start`.
- R9: `unit_in_valid[u]` is high in the cycle after each read made by unit `u`, and only then.
- R10: A table write stores FIFO index (2 bits), unit index (1 bit), launch (12 bits) and `len` (8 bits) at `tbl_idx` when `tbl_wr` is high. A start with `sched_count = n` uses entries 0 to n-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tbl_wr | input | 1 | Table entry write strobe |
| tbl_idx | input | 3 | Table entry address |
| tbl_fifo | input | 2 | Source FIFO / output lane of the entry |
| tbl_unit | input | 1 | Processing unit of the entry |
| tbl_launch | input | 12 | Earliest schedule cycle of the entry |
| tbl_len | input | 8 | Pixel count of the entry |
| sched_start | input | 1 | Restarts the schedule clock and the sequencers |
| sched_count | input | 4 | Number of valid table entries for this run |
| fifo_data | input | 64 | Head words of the four FIFOs, FIFO f at bits 16f+15:16f |
| fifo_ready | input | 4 | Complete pixel set present, per FIFO |
| fifo_empty | input | 4 | FIFO empty, per FIFO |
| fifo_rd | output | 4 | Read enable, per FIFO |
| unit_in_valid | output | 2 | Word valid into each unit |
| unit_in_data | output | 32 | Word into each unit, unit u at bits 16u+15:16u |
| unit_out_data | input | 32 | Result from each unit, 15 cycles after its input |
| lane_valid | output | 4 | Result valid, per output lane |
| lane_data | output | 64 | Result data, lane f at bits 16f+15:16f |
| sched_err | output | 1 | Sticky flag for overlapping table windows |

## Verification
The hardest case to reach is a unit whose next start depends on three limits at once: the table launch value, the end of its previous task, and a FIFO that becomes ready late. The sweep varies launch offsets, task lengths and ready times together. As a result, each of the three limits sets the start cycle in some runs, and in some runs two of them tie. A separate run builds a table with an overlapping window on one unit, and the runs that follow confirm that the next start clears the flag.

// File: rtl/sched_disp_pkg.sv
package sched_disp_pkg;

    localparam int NUM_FIFO  = 4;
    localparam int NUM_UNIT  = 2;
    localparam int TBL_DEPTH = 8;
    localparam int TIME_W    = 12;
    localparam int LEN_W     = 8;

    localparam int FIFO_W = (NUM_FIFO > 1) ? $clog2(NUM_FIFO) : 1;
    localparam int UNIT_W = (NUM_UNIT > 1) ? $clog2(NUM_UNIT) : 1;
    localparam int IDX_W  = (TBL_DEPTH > 1) ? $clog2(TBL_DEPTH) : 1;

    typedef struct packed {
        logic [FIFO_W-1:0] fifo;
        logic [UNIT_W-1:0] unit;
        logic [TIME_W-1:0] launch;
        logic [LEN_W-1:0]  len;
    } entry_t;

    typedef struct packed {
        logic              v;
        logic [FIFO_W-1:0] lane;
    } tag_t;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_WAIT = 2'd1,
        SEQ_RUN  = 2'd2
    } seq_st_e;

endpackage

// File: rtl/sched_table.sv
module sched_table
    import sched_disp_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [IDX_W-1:0]            wr_idx,
    input  entry_t                      wr_entry,
    output entry_t [TBL_DEPTH-1:0]      tbl
);

    typedef struct packed {
        entry_t [TBL_DEPTH-1:0] e;
    } tbl_s;

    tbl_s t_d, t_q;

    always_comb begin
        t_d = t_q;
        if (wr_en) begin
            t_d.e[wr_idx] = wr_entry;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    assign tbl = t_q.e;

endmodule

// File: rtl/sched_seq.sv
module sched_seq
    import sched_disp_pkg::*;
#(
    parameter int UNIT_ID = 0
)(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic [IDX_W:0]          start_count,
    input  entry_t [TBL_DEPTH-1:0]  tbl,
    input  logic [TIME_W-1:0]       now,
    input  logic [NUM_FIFO-1:0]     fifo_ready,
    input  logic [NUM_FIFO-1:0]     fifo_empty,
    output logic                    rd,
    output logic [FIFO_W-1:0]       rd_fifo,
    output logic                    overlap
);

    typedef struct packed {
        seq_st_e          st;
        logic [IDX_W-1:0] ptr;
        logic [IDX_W:0]   num;
        logic [LEN_W-1:0] rem;
        entry_t           cur;
    } seq_s;

    seq_s s_d, s_q;

    logic             go;
    logic             advance;
    logic             found;
    logic [IDX_W-1:0] nidx;
    logic [IDX_W:0]   from;
    logic [IDX_W:0]   lim;

    always_comb begin
        from = start ? '0 : ({1'b0, s_q.ptr} + 1'b1);
        lim  = start ? start_count : s_q.num;
        found = 1'b0;
        nidx  = '0;
        for (int i = 0; i < TBL_DEPTH; i++) begin
            if (!found && ((IDX_W+1)'(i) >= from) && ((IDX_W+1)'(i) < lim) &&
                (tbl[i].unit == UNIT_W'(UNIT_ID))) begin
                found = 1'b1;
                nidx  = IDX_W'(i);
            end
        end
    end

    always_comb begin
        s_d     = s_q;
        rd      = 1'b0;
        overlap = 1'b0;
        advance = 1'b0;
        go      = (s_q.st == SEQ_WAIT) && (now >= s_q.cur.launch) &&
                  fifo_ready[s_q.cur.fifo] && !fifo_empty[s_q.cur.fifo];

        if (start) begin
            s_d.num = start_count;
            advance = 1'b1;
        end else begin
            case (s_q.st)
                SEQ_WAIT: begin
                    if (go) begin
                        rd = 1'b1;
                        if (s_q.cur.len <= 1) begin
                            advance = 1'b1;
                        end else begin
                            s_d.st  = SEQ_RUN;
                            s_d.rem = s_q.cur.len - 1'b1;
                        end
                    end
                end
                SEQ_RUN: begin
                    rd      = 1'b1;
                    s_d.rem = s_q.rem - 1'b1;
                    if (s_q.rem <= 1) advance = 1'b1;
                end
                default: ;
            endcase
        end

        if (advance) begin
            if (found) begin
                if (!start && (int'(tbl[nidx].launch) <
                               int'(s_q.cur.launch) + int'(s_q.cur.len))) begin
                    overlap = 1'b1;
                end
                s_d.cur = tbl[nidx];
                s_d.ptr = nidx;
                s_d.st  = SEQ_WAIT;
            end else begin
                s_d.st  = SEQ_IDLE;
            end
        end
    end

    assign rd_fifo = s_q.cur.fifo;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{st: SEQ_IDLE, default: '0};
        else        s_q <= s_d;
    end

    assert_launch_not_early_R2: assert property (
        @(posedge clk) disable iff (!rst_n)
        rd |-> (now >= s_q.cur.launch)
    );

    assert_no_interrupt_R5: assert property (
        @(posedge clk) disable iff (!rst_n)
        (s_q.st == SEQ_RUN && s_q.rem > 1 && !start) |=>
            (s_q.st == SEQ_RUN && $stable(s_q.ptr))
    );

endmodule

// File: rtl/sched_route.sv
module sched_route
    import sched_disp_pkg::*;
#(
    parameter int DATA_W   = 16,
    parameter int UNIT_LAT = 15
)(
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic [NUM_UNIT-1:0]                  rd,
    input  logic [NUM_UNIT-1:0][FIFO_W-1:0]      rd_fifo,
    input  logic [NUM_FIFO-1:0][DATA_W-1:0]      fifo_word,
    input  logic [NUM_UNIT-1:0][DATA_W-1:0]      unit_result,
    output logic [NUM_UNIT-1:0]                  feed_valid,
    output logic [NUM_UNIT-1:0][DATA_W-1:0]      feed_data,
    output logic [NUM_FIFO-1:0]                  out_valid,
    output logic [NUM_FIFO-1:0][DATA_W-1:0]      out_data
);

    typedef struct packed {
        logic [NUM_UNIT-1:0]                fv;
        logic [NUM_UNIT-1:0][DATA_W-1:0]    fd;
        tag_t [NUM_UNIT-1:0][UNIT_LAT:0]    tag;
        logic [NUM_FIFO-1:0]                ov;
        logic [NUM_FIFO-1:0][DATA_W-1:0]    od;
    } route_s;

    route_s r_d, r_q;

    always_comb begin
        r_d = r_q;
        for (int u = 0; u < NUM_UNIT; u++) begin
            r_d.fv[u]          = rd[u];
            r_d.fd[u]          = fifo_word[rd_fifo[u]];
            r_d.tag[u][0].v    = rd[u];
            r_d.tag[u][0].lane = rd_fifo[u];
            for (int k = 1; k <= UNIT_LAT; k++) begin
                r_d.tag[u][k] = r_q.tag[u][k-1];
            end
        end
        for (int l = 0; l < NUM_FIFO; l++) begin
            r_d.ov[l] = 1'b0;
            r_d.od[l] = '0;
            for (int u = NUM_UNIT - 1; u >= 0; u--) begin
                if (r_q.tag[u][UNIT_LAT].v && (r_q.tag[u][UNIT_LAT].lane == FIFO_W'(l))) begin
                    r_d.ov[l] = 1'b1;
                    r_d.od[l] = unit_result[u];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign feed_valid = r_q.fv;
    assign feed_data  = r_q.fd;
    assign out_valid  = r_q.ov;
    assign out_data   = r_q.od;

    assert_lane_bound_R6: assert property (
        @(posedge clk) disable iff (!rst_n)
        $countones(r_q.ov) <= NUM_UNIT
    );

endmodule

// File: rtl/sched_dispatch.sv
module sched_dispatch
    import sched_disp_pkg::*;
#(
    parameter int DATA_W   = 16,
    parameter int UNIT_LAT = 15
)(
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         tbl_wr,
    input  logic [IDX_W-1:0]             tbl_idx,
    input  logic [FIFO_W-1:0]            tbl_fifo,
    input  logic [UNIT_W-1:0]            tbl_unit,
    input  logic [TIME_W-1:0]            tbl_launch,
    input  logic [LEN_W-1:0]             tbl_len,
    input  logic                         sched_start,
    input  logic [IDX_W:0]               sched_count,
    input  logic [NUM_FIFO*DATA_W-1:0]   fifo_data,
    input  logic [NUM_FIFO-1:0]          fifo_ready,
    input  logic [NUM_FIFO-1:0]          fifo_empty,
    output logic [NUM_FIFO-1:0]          fifo_rd,
    output logic [NUM_UNIT-1:0]          unit_in_valid,
    output logic [NUM_UNIT*DATA_W-1:0]   unit_in_data,
    input  logic [NUM_UNIT*DATA_W-1:0]   unit_out_data,
    output logic [NUM_FIFO-1:0]          lane_valid,
    output logic [NUM_FIFO*DATA_W-1:0]   lane_data,
    output logic                         sched_err
);

    typedef struct packed {
        logic [TIME_W-1:0] t;
        logic              err;
    } top_s;

    top_s c_d, c_q;

    entry_t                          wr_entry;
    entry_t [TBL_DEPTH-1:0]          tbl;
    logic [NUM_UNIT-1:0]             rd;
    logic [NUM_UNIT-1:0][FIFO_W-1:0] rd_fifo;
    logic [NUM_UNIT-1:0]             ovl;
    logic [NUM_FIFO-1:0][DATA_W-1:0] fifo_word;
    logic [NUM_UNIT-1:0][DATA_W-1:0] unit_result;
    logic [NUM_UNIT-1:0][DATA_W-1:0] feed_data;
    logic [NUM_FIFO-1:0][DATA_W-1:0] out_data;

    assign wr_entry    = '{fifo: tbl_fifo, unit: tbl_unit, launch: tbl_launch, len: tbl_len};
    assign fifo_word   = fifo_data;
    assign unit_result = unit_out_data;
    assign unit_in_data = feed_data;
    assign lane_data   = out_data;

    sched_table u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (tbl_wr),
        .wr_idx   (tbl_idx),
        .wr_entry (wr_entry),
        .tbl      (tbl)
    );

    for (genvar u = 0; u < NUM_UNIT; u++) begin : g_seq
        sched_seq #(.UNIT_ID(u)) u_seq (
            .clk         (clk),
            .rst_n       (rst_n),
            .start       (sched_start),
            .start_count (sched_count),
            .tbl         (tbl),
            .now         (c_q.t),
            .fifo_ready  (fifo_ready),
            .fifo_empty  (fifo_empty),
            .rd          (rd[u]),
            .rd_fifo     (rd_fifo[u]),
            .overlap     (ovl[u])
        );
    end

    sched_route #(.DATA_W(DATA_W), .UNIT_LAT(UNIT_LAT)) u_route (
        .clk         (clk),
        .rst_n       (rst_n),
        .rd          (rd),
        .rd_fifo     (rd_fifo),
        .fifo_word   (fifo_word),
        .unit_result (unit_result),
        .feed_valid  (unit_in_valid),
        .feed_data   (feed_data),
        .out_valid   (lane_valid),
        .out_data    (out_data)
    );

    always_comb begin
        c_d = c_q;
        if (sched_start) begin
            c_d.t   = '0;
            c_d.err = 1'b0;
        end else begin
            if (c_q.t != '1) c_d.t = c_q.t + 1'b1;
            if (|ovl) c_d.err = 1'b1;
        end
    end

    always_comb begin
        fifo_rd = '0;
        for (int f = 0; f < NUM_FIFO; f++) begin
            for (int u = 0; u < NUM_UNIT; u++) begin
                if (rd[u] && (rd_fifo[u] == FIFO_W'(f))) fifo_rd[f] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign sched_err = c_q.err;

    assert_err_sticky_R8: assert property (
        @(posedge clk) disable iff (!rst_n)
        (c_q.err && !sched_start) |=> c_q.err
    );

    for (genvar f = 0; f < NUM_FIFO; f++) begin : g_chk
        assert_read_gated_R4: assert property (
            @(posedge clk) disable iff (!rst_n)
            (fifo_rd[f] && !$past(fifo_rd[f])) |-> (fifo_ready[f] && !fifo_empty[f])
        );
    end

endmodule

// File: tb/sched_dispatch_tb.sv
module sched_dispatch_tb;
    import sched_disp_pkg::*;

    localparam int DW    = 16;
    localparam int LAT   = 15;
    localparam int PATH  = LAT + 2;
    localparam int STEPS = 56;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic                        tbl_wr = 1'b0;
    logic [IDX_W-1:0]            tbl_idx = '0;
    logic [FIFO_W-1:0]           tbl_fifo = '0;
    logic [UNIT_W-1:0]           tbl_unit = '0;
    logic [TIME_W-1:0]           tbl_launch = '0;
    logic [LEN_W-1:0]            tbl_len = '0;
    logic                        sched_start = 1'b0;
    logic [IDX_W:0]              sched_count = '0;
    logic [NUM_FIFO*DW-1:0]      fifo_data;
    logic [NUM_FIFO-1:0]         fifo_ready = '0;
    logic [NUM_FIFO-1:0]         fifo_empty = '1;
    logic [NUM_FIFO-1:0]         fifo_rd;
    logic [NUM_UNIT-1:0]         unit_in_valid;
    logic [NUM_UNIT*DW-1:0]      unit_in_data;
    logic [NUM_UNIT*DW-1:0]      unit_out_data;
    logic [NUM_FIFO-1:0]         lane_valid;
    logic [NUM_FIFO*DW-1:0]      lane_data;
    logic                        sched_err;

    sched_dispatch #(.DATA_W(DW), .UNIT_LAT(LAT)) u_dut (
        .clk(clk), .rst_n(rst_n), .tbl_wr(tbl_wr), .tbl_idx(tbl_idx),
        .tbl_fifo(tbl_fifo), .tbl_unit(tbl_unit), .tbl_launch(tbl_launch),
        .tbl_len(tbl_len), .sched_start(sched_start), .sched_count(sched_count),
        .fifo_data(fifo_data), .fifo_ready(fifo_ready), .fifo_empty(fifo_empty),
        .fifo_rd(fifo_rd), .unit_in_valid(unit_in_valid), .unit_in_data(unit_in_data),
        .unit_out_data(unit_out_data), .lane_valid(lane_valid), .lane_data(lane_data),
        .sched_err(sched_err)
    );

    function automatic logic [DW-1:0] ukey(input int u);
        return 16'h3C3C ^ 16'(u * 16'h1111 + 16'h0101);
    endfunction

    // fixed-latency unit models
    logic [DW-1:0] upipe [NUM_UNIT][LAT];
    always @(posedge clk) begin
        for (int u = 0; u < NUM_UNIT; u++) begin
            upipe[u][0] <= unit_in_data[u*DW +: DW] ^ ukey(u);
            for (int k = 1; k < LAT; k++) upipe[u][k] <= upipe[u][k-1];
        end
    end
    always_comb begin
        for (int u = 0; u < NUM_UNIT; u++) unit_out_data[u*DW +: DW] = upipe[u][LAT-1];
    end

    // FIFO head models
    logic        fclr = 1'b0;
    logic [11:0] fcnt [NUM_FIFO];
    always @(posedge clk) begin
        for (int f = 0; f < NUM_FIFO; f++) begin
            if (fclr)            fcnt[f] <= '0;
            else if (fifo_rd[f]) fcnt[f] <= fcnt[f] + 1'b1;
        end
    end
    always_comb begin
        for (int f = 0; f < NUM_FIFO; f++) fifo_data[f*DW +: DW] = {4'(f), fcnt[f]};
    end

    int total = 0;
    int bad = 0;
    int cyc = 0;

    task automatic check(input int act, input int exp, input string what);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            bad++; total++;
            $display("FAIL watchdog R1: actual=%0d expected=%0d", cyc, 150000);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // scenario description
    int e_f [4];
    int e_u [4];
    int e_l [4];
    int e_n [4];
    int e_cnt;
    int rdy_at [4];
    int exp_err;

    task automatic run_case();
        int uend [NUM_UNIT];
        int uexp [NUM_UNIT];
        int expd [NUM_FIFO];
        int expn [NUM_FIFO];
        int uof  [NUM_FIFO];
        int frst [NUM_FIFO];
        int flst [NUM_FIFO];
        int nrd  [NUM_FIFO];
        int lfst [NUM_FIFO];
        int llst [NUM_FIFO];
        int nl   [NUM_FIFO];
        int wk   [NUM_FIFO];
        int derr [NUM_FIFO];
        int nin  [NUM_UNIT];
        for (int u = 0; u < NUM_UNIT; u++) begin uend[u] = 0; uexp[u] = 0; nin[u] = 0; end
        for (int f = 0; f < NUM_FIFO; f++) begin
            expd[f] = -1; expn[f] = 0; uof[f] = 0;
            frst[f] = -1; flst[f] = -1; nrd[f] = 0;
            lfst[f] = -1; llst[f] = -1; nl[f] = 0; wk[f] = 0; derr[f] = 0;
        end
        // expected start: latest of launch, unit free, FIFO ready
        for (int i = 0; i < e_cnt; i++) begin
            int d;
            d = e_l[i];
            if (uend[e_u[i]] > d) d = uend[e_u[i]];
            if (rdy_at[e_f[i]] > d) d = rdy_at[e_f[i]];
            expd[e_f[i]] = d;
            expn[e_f[i]] = e_n[i];
            uof[e_f[i]]  = e_u[i];
            uend[e_u[i]] = d + e_n[i];
            uexp[e_u[i]] += e_n[i];
        end
        // table load (R10 encoding)
        @(negedge clk);
        fclr = 1'b1;
        for (int i = 0; i < e_cnt; i++) begin
            tbl_wr = 1'b1;
            tbl_idx = IDX_W'(i);
            tbl_fifo = FIFO_W'(e_f[i]);
            tbl_unit = UNIT_W'(e_u[i]);
            tbl_launch = TIME_W'(e_l[i]);
            tbl_len = LEN_W'(e_n[i]);
            @(negedge clk);
        end
        tbl_wr = 1'b0;
        fclr = 1'b0;
        sched_start = 1'b1;
        sched_count = (IDX_W+1)'(e_cnt);
        @(negedge clk);
        sched_start = 1'b0;
        for (int t = 0; t < STEPS; t++) begin
            for (int f = 0; f < NUM_FIFO; f++) begin
                fifo_ready[f] = (t >= rdy_at[f]);
                fifo_empty[f] = !(t >= rdy_at[f]);
            end
            #1;
            for (int f = 0; f < NUM_FIFO; f++) begin
                if (fifo_rd[f]) begin
                    if (frst[f] < 0) frst[f] = t;
                    flst[f] = t;
                    nrd[f]++;
                end
                if (lane_valid[f]) begin
                    if (lfst[f] < 0) lfst[f] = t;
                    llst[f] = t;
                    nl[f]++;
                    if (lane_data[f*DW +: DW] != ({4'(f), 12'(wk[f])} ^ ukey(uof[f]))) derr[f]++;
                    wk[f]++;
                end
            end
            for (int u = 0; u < NUM_UNIT; u++) if (unit_in_valid[u]) nin[u]++;
            @(negedge clk);
        end
        fifo_ready = '0;
        fifo_empty = '1;
        for (int f = 0; f < NUM_FIFO; f++) begin
            check(frst[f], expd[f], $sformatf("R2 R4 R5 R10 first read fifo %0d", f));
            check(nrd[f], expn[f], $sformatf("R3 read count fifo %0d", f));
            check(flst[f], (expn[f] > 0) ? expd[f] + expn[f] - 1 : -1,
                  $sformatf("R3 last read fifo %0d", f));
            check(lfst[f], (expd[f] >= 0) ? expd[f] + PATH : -1,
                  $sformatf("R6 first beat lane %0d", f));
            check(llst[f], (expn[f] > 0) ? expd[f] + PATH + expn[f] - 1 : -1,
                  $sformatf("R6 last beat lane %0d", f));
            check(derr[f], 0, $sformatf("R7 data mismatches lane %0d", f));
        end
        for (int u = 0; u < NUM_UNIT; u++)
            check(nin[u], uexp[u], $sformatf("R9 feed beats unit %0d", u));
        check(int'(sched_err), exp_err, "R8 overlap flag");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(int'(fifo_rd), 0, "R1 fifo_rd in reset");
        check(int'(lane_valid), 0, "R1 lane_valid in reset");
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check(int'(fifo_rd), 0, "R1 fifo_rd after reset");
        check(int'(unit_in_valid), 0, "R1 unit_in_valid after reset");
        check(int'(lane_valid), 0, "R1 lane_valid after reset");
        check(int'(sched_err), 0, "R1 sched_err after reset");

        // overlapping windows on unit 0: flag expected, second task still waits (R5, R8)
        e_cnt = 2; exp_err = 1;
        e_f[0] = 0; e_u[0] = 0; e_l[0] = 0; e_n[0] = 5;
        e_f[1] = 1; e_u[1] = 0; e_l[1] = 3; e_n[1] = 2;
        for (int f = 0; f < 4; f++) rdy_at[f] = 0;
        run_case();

        // sweep of launch offset and length; the first run also shows the flag cleared (R8)
        for (int la = 0; la < 4; la++) begin
            for (int lb = 1; lb <= 4; lb++) begin
                e_cnt = 4; exp_err = 0;
                e_f[0] = 2; e_u[0] = 1; e_l[0] = 2;       e_n[0] = lb;
                e_f[1] = 0; e_u[1] = 0; e_l[1] = la;      e_n[1] = lb;
                e_f[2] = 3; e_u[2] = 1; e_l[2] = 2 + lb;  e_n[2] = 2;
                e_f[3] = 1; e_u[3] = 0; e_l[3] = la + lb; e_n[3] = 3;
                rdy_at[0] = lb;
                rdy_at[1] = 0;
                rdy_at[2] = 0;
                rdy_at[3] = la * 3 + 2;
                run_case();
            end
        end

        // single-beat tasks, both units, one FIFO never ready until late (R3 R4)
        e_cnt = 3; exp_err = 0;
        e_f[0] = 3; e_u[0] = 0; e_l[0] = 0; e_n[0] = 1;
        e_f[1] = 2; e_u[1] = 1; e_l[1] = 0; e_n[1] = 1;
        e_f[2] = 0; e_u[2] = 0; e_l[2] = 1; e_n[2] = 1;
        rdy_at[0] = 9; rdy_at[1] = 0; rdy_at[2] = 4; rdy_at[3] = 0;
        run_case();

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule